// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block gathers event flags from a FIFO-based serial controller into a 32-bit interrupt status word. Each flagged condition is kept sticky in that word until software flips it back, and a single level interrupt line is produced when any status bit that is also enabled is set and the master enable is on.

Software reaches three registers over a plain 32-bit register bus with byte addresses. There is one write strobe. Reads are combinational from the addressed register.

Software clears a status bit by writing a 1 to it, and the written value is XORed into the word. Writing 1 to a clear bit therefore sets it, which lets software raise an interrupt on purpose. A hardware event always wins over a software flip of the same bit in the same cycle, so no event is lost.

The six event inputs fall into two kinds. Receive-not-empty and receive-full are levels: they are asserted again on every cycle the condition holds, so they cannot be cleared while it lasts. The other four are edge events that stay latched.

Top module: `irq_status_agg`

## Requirements
- R1: An event input sampled high at a clock edge sets its status bit in that same edge. The bit positions are: receive-not-empty bit 8, receive-full bit 4, receive-overrun bit 5, transmit-empty bit 2, transmit-underrun bit 3, transmit-half-empty bit 6.
- R2: A write to byte offset 0x20 XORs the write data into all 32 status bits, so every written 1 flips its bit. Reading offset 0x20 returns the status word.
- R3: While receive-not-empty or receive-full is held high, software cannot clear its bit. Once the input is low, one toggle clears it.
- R4: A status bit set by receive-overrun, transmit-empty, transmit-underrun or transmit-half-empty stays set with no write and no event, until software toggles it.
- R5: If an event and a software toggle hit the same status bit in the same cycle, the bit is 1 afterwards.
- R6: Byte offset 0x28 holds a 32-bit per-bit enable word, written and read back in full.
- R7: Byte offset 0x1C holds the global enable in bit 31. Its other bits read as 0 and ignore writes. While the global enable is 0, the interrupt output is 0.
- R8: The interrupt output is a flop. On a given clock edge it takes (global enable AND any bit of (status AND enable)), using the register values held before that edge. It therefore follows a register change one cycle later.
- R9: With rst_n low at a clock edge, the edge clears status, enable and global enable, and drives the interrupt output low.
- R10: Writes to any other offset change nothing, and reads of any other offset return 0. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| rx_nempty_i | input | 1 | Receive FIFO not empty (level) |
| rx_full_i | input | 1 | Receive FIFO full (level) |
| rx_ovr_i | input | 1 | Receive overrun event |
| tx_empty_i | input | 1 | Transmit FIFO emptied event |
| tx_udr_i | input | 1 | Transmit underrun event |
| tx_half_i | input | 1 | Transmit FIFO half-empty event |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The collision that matters is a hardware event setting a status bit in the same cycle that software XORs a 1 into that bit. Directed cases provoke it by writing a toggle to bit 8 while receive-not-empty is held high. The random phase provokes it by mixing frequent status writes with random event pulses. Each case is judged by reading the status word in the next cycle, where the colliding bit must be 1, and by checking the interrupt output one cycle later. A second overlap, a write to the global enable while an enabled bit is pending, is judged on the one-cycle delay of the interrupt output.

// File: rtl/isa_pkg.sv
// Package: shared constants for the interrupt status aggregator.
// Assumes a 32-bit register word and byte addressing.
package isa_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_EV   = 6;
    localparam int unsigned GIE_BIT  = 31;
    localparam int unsigned OFF_GIE  = 32'h1C;
    localparam int unsigned OFF_STAT = 32'h20;
    localparam int unsigned OFF_EN   = 32'h28;

    // Event index order: 0 rx not empty, 1 rx full, 2 rx overrun,
    // 3 tx empty, 4 tx underrun, 5 tx half empty.
    function automatic int unsigned ev_bit(input int unsigned idx);
        case (idx)
            0:       return 8;
            1:       return 4;
            2:       return 5;
            3:       return 2;
            4:       return 3;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/isa_event_map.sv
// Module: isa_event_map
// Spreads the event inputs onto their status bit positions.
// Assumes the positions given by isa_pkg::ev_bit are distinct and below DATA_W.
module isa_event_map
    import isa_pkg::*;
(
    input  logic [NUM_EV-1:0] ev_i,
    output logic [DATA_W-1:0] set_vec_o
);
    // Place each event on its own status bit.
    always_comb begin
        set_vec_o = '0;
        for (int unsigned i = 0; i < NUM_EV; i++) begin
            set_vec_o[ev_bit(i)] = ev_i[i];
        end
    end
endmodule

// File: rtl/isa_status_reg.sv
// Module: isa_status_reg
// Status word: software XOR toggles, hardware set wins in the same cycle.
// Assumes tgl_en is a single-cycle write strobe.
module isa_status_reg
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgl_en,
    input  logic [DATA_W-1:0] tgl_val,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] status_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic flip;
        assign flip = tgl_en & tgl_val[b];
        // One sticky bit: toggle first, then OR the hardware set on top.
        always_ff @(posedge clk) begin
            if (!rst_n) status_o[b] <= 1'b0;
            else        status_o[b] <= (status_o[b] ^ flip) | set_vec[b];
        end
    end

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_o & $past(set_vec)) == $past(set_vec)));
    assert_toggle_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_en && set_vec == '0) |=> (status_o == ($past(status_o) ^ $past(tgl_val))));
    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgl_en && set_vec == '0) |=> $stable(status_o));
endmodule

// File: rtl/isa_ctrl_regs.sv
// Module: isa_ctrl_regs
// Per-bit enable word and the global enable flag.
// Assumes the write strobes are already decoded from the address.
module isa_ctrl_regs
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_word,
    input  logic              wr_gie,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_o,
    output logic              gie_o
);
    // Load the enable word on its write.
    always_ff @(posedge clk) begin
        if (!rst_n)          en_o <= '0;
        else if (wr_en_word) en_o <= wdata;
    end

    // Capture only the global enable bit of its register.
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_o <= 1'b0;
        else if (wr_gie) gie_o <= wdata[GIE_BIT];
    end

    assert_en_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_word |=> (en_o == $past(wdata)));
    assert_gie_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gie |=> $stable(gie_o));
endmodule

// File: rtl/isa_irq_gate.sv
// Module: isa_irq_gate
// Registered interrupt: global enable AND any enabled pending bit.
// Assumes inputs are flop outputs, so the flop sees a clean value.
module isa_irq_gate
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] en,
    input  logic              gie,
    output logic              irq_o
);
    logic pend;
    assign pend = |(status & en);

    // Register the gated request so the output has no glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= gie & pend;
    end

    assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq_o);
    assert_no_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & en) == '0) |=> !irq_o);
    assert_rise_needs_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(gie));
endmodule

// File: rtl/irq_status_agg.sv
// Module: irq_status_agg (top)
// Decodes the register bus and joins the event map, the status word,
// the control registers and the interrupt gate.
// Assumes single-cycle writes and combinational reads; address bits 1:0 are ignored.
module irq_status_agg
    import isa_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_nempty_i,
    input  logic              rx_full_i,
    input  logic              rx_ovr_i,
    input  logic              tx_empty_i,
    input  logic              tx_udr_i,
    input  logic              tx_half_i,
    output logic              irq_o
);
    localparam int unsigned WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] W_GIE  = WA_W'(OFF_GIE / 4);
    localparam logic [WA_W-1:0] W_STAT = WA_W'(OFF_STAT / 4);
    localparam logic [WA_W-1:0] W_EN   = WA_W'(OFF_EN / 4);

    logic [WA_W-1:0]   word;
    logic              hit_gie, hit_stat, hit_en;
    logic [NUM_EV-1:0] ev;
    logic [DATA_W-1:0] set_vec, status, en;
    logic              gie;

    assign word     = bus_addr[ADDR_W-1:2];
    assign hit_gie  = (word == W_GIE);
    assign hit_stat = (word == W_STAT);
    assign hit_en   = (word == W_EN);
    assign ev       = {tx_half_i, tx_udr_i, tx_empty_i, rx_ovr_i, rx_full_i, rx_nempty_i};

    isa_event_map u_map (
        .ev_i      (ev),
        .set_vec_o (set_vec)
    );

    isa_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgl_en   (bus_wr & hit_stat),
        .tgl_val  (bus_wdata),
        .set_vec  (set_vec),
        .status_o (status)
    );

    isa_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_word (bus_wr & hit_en),
        .wr_gie     (bus_wr & hit_gie),
        .wdata      (bus_wdata),
        .en_o       (en),
        .gie_o      (gie)
    );

    isa_irq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .en     (en),
        .gie    (gie),
        .irq_o  (irq_o)
    );

    // Read mux over the three mapped registers; anything else reads 0.
    always_comb begin
        if (hit_stat)     bus_rdata = status;
        else if (hit_en)  bus_rdata = en;
        else if (hit_gie) bus_rdata = {gie, 31'b0};
        else              bus_rdata = '0;
    end

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && en == '0 && !gie && !irq_o));
    assert_level_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nempty_i |=> status[ev_bit(0)]);
endmodule

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  ev = '0;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_st, m_en;
    logic        m_gie, m_irq;

    always #(CLK_P/2) clk = ~clk;

    irq_status_agg #(.ADDR_W(8)) i_irq_status_agg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_nempty_i(ev[0]), .rx_full_i(ev[1]), .rx_ovr_i(ev[2]),
        .tx_empty_i(ev[3]), .tx_udr_i(ev[4]), .tx_half_i(ev[5]),
        .irq_o(irq_o)
    );

    // Event bit positions from R1.
    function automatic logic [31:0] set_of(input logic [5:0] e);
        logic [31:0] s = '0;
        s[8] = e[0]; s[4] = e[1]; s[5] = e[2];
        s[2] = e[3]; s[3] = e[4]; s[6] = e[5];
        return s;
    endfunction

    function automatic logic [31:0] read_of(input logic [7:0] a);
        case (a[7:2])
            6'h07:   return {m_gie, 31'b0};
            6'h08:   return m_st;
            6'h0A:   return m_en;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a[7:2])
            6'h07:   return "R7";
            6'h08:   return "R2";
            6'h0A:   return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, step model at posedge, compare at negedge.
    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [5:0] e, input string tag);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ev = e;
        @(posedge clk);
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_gie = 1'b0; m_irq = 1'b0;
        end else begin
            m_irq = m_gie & (|(m_st & m_en));
            if (wr && a[7:2] == 6'h08) m_st = m_st ^ d;
            m_st = m_st | set_of(e);
            if (wr && a[7:2] == 6'h0A) m_en = d;
            if (wr && a[7:2] == 6'h07) m_gie = d[31];
        end
        @(negedge clk);
        chk(bus_rdata, read_of(a), $sformatf("%s rdata @%h", tag, a));
        chk({31'b0, irq_o}, {31'b0, m_irq}, $sformatf("%s irq", tag));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R9: reset state
        cyc(0, 8'h20, 0, 6'h3F, "R9");
        cyc(0, 8'h20, 0, 0, "R9");
        rst_n = 1'b1;
        cyc(0, 8'h28, 0, 0, "R9");
        cyc(0, 8'h1C, 0, 0, "R9");
        chk(bus_rdata, 32'h0, "R9 gie after reset");
        // R1: each edge event on its bit
        cyc(0, 8'h20, 0, 6'b000100, "R1");
        chk(bus_rdata, 32'h20, "R1 overrun bit 5");
        cyc(0, 8'h20, 0, 6'b001000, "R1");
        cyc(0, 8'h20, 0, 6'b010000, "R1");
        cyc(0, 8'h20, 0, 6'b100000, "R1");
        chk(bus_rdata, 32'h6C, "R1 bits 2,3,5,6");
        cyc(0, 8'h20, 0, 6'b000010, "R1");
        chk(bus_rdata, 32'h7C, "R1 rx full bit 4");
        // R4: edge-set bits hold
        for (int i = 0; i < 5; i++) cyc(0, 8'h20, 0, 0, "R4");
        chk(bus_rdata, 32'h7C, "R4 held");
        // R2: XOR toggle clears and sets
        cyc(1, 8'h20, 32'h8000_0024, 0, "R2");
        chk(bus_rdata, 32'h8000_0058, "R2 xor");
        // R5 / R3: toggle bit 8 while rx not-empty held
        cyc(0, 8'h20, 0, 6'b000001, "R3");
        cyc(1, 8'h20, 32'h100, 6'b000001, "R5");
        chk(bus_rdata[8], 1'b1, "R5 event beats toggle");
        cyc(1, 8'h21, 32'h100, 6'b000001, "R3");
        chk(bus_rdata[8], 1'b1, "R3 level sticky");
        cyc(1, 8'h20, 32'h100, 0, "R3");
        chk(bus_rdata[8], 1'b0, "R3 clears after release");
        // R6, R7, R8: enable and gating
        cyc(1, 8'h28, 32'h40, 0, "R6");
        chk(bus_rdata, 32'h40, "R6 enable readback");
        cyc(1, 8'h20, 32'h40, 6'b100000, "R7");
        cyc(0, 8'h20, 0, 0, "R7");
        chk({31'b0, irq_o}, 0, "R7 gie off blocks irq");
        cyc(1, 8'h1C, 32'hFFFF_FFFF, 0, "R7");
        chk(bus_rdata, 32'h8000_0000, "R7 only bit 31");
        chk({31'b0, irq_o}, 0, "R8 one cycle delay");
        cyc(0, 8'h1C, 0, 0, "R8");
        chk({31'b0, irq_o}, 1, "R8 irq rises");
        // R10: unmapped offsets
        cyc(1, 8'h24, 32'hFFFF_FFFF, 0, "R10");
        cyc(1, 8'h00, 32'hFFFF_FFFF, 0, "R10");
        chk(bus_rdata, 0, "R10 unmapped read");
        cyc(0, 8'h28, 0, 0, "R10");
        chk(bus_rdata, 32'h40, "R10 enable untouched");
        // R9: reset mid run
        rst_n = 1'b0;
        cyc(1, 8'h28, 32'h1, 6'h3F, "R9");
        rst_n = 1'b1;
        cyc(0, 8'h20, 0, 0, "R9");
        chk(bus_rdata, 0, "R9 status cleared");
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            logic [5:0] e;
            case ($urandom % 6)
                0: a = 8'h1C; 1, 2: a = 8'h20; 3: a = 8'h28;
                4: a = 8'h24; default: a = 8'h00;
            endcase
            e = '0;
            for (int k = 0; k < 6; k++) e[k] = (($urandom % 8) == 0);
            if (($urandom % 200) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            cyc(($urandom % 2) == 1, a, $urandom, e, tag_of(a));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule